// File: doc/BRIEF.md
# Microcontroller Port Bit Logic

This block holds the digital side of three 8-bit microcontroller ports, each with its own personality. Port A is input only. Each of its upper bits is either routed to an analog converter or used as a digital input, chosen by its latch bit. Port B is a general-purpose port that an external-memory cycle can take over: while the memory-mode flag is high, its pins carry an address byte push-pull. Port C is a general-purpose port whose pins can also carry peripheral outputs. A peripheral output only reaches a Port C pin when that bit's latch holds 1.

Software writes a latch with a strobe, a port select and a data byte. Each port has two read paths. One returns the latch contents and serves read-modify-write operations. The other returns the pin level after a two-flop synchronizer and serves plain reads. A single read flag picks which of the two appears on the combined read data. Pin drive is given only as drive-low and drive-high enables. A bit with neither enable set is left to the weak pull-up.

Top module: `gpio_port_bits`

## Requirements
- R1: After reset every latch bit of all three ports is 1, so analog select is set on Port A bits 2 to 7, and no Port B or Port C pin is driven low.
- R2: The analog select of Port A bit i equals latch bit i for i from 2 to 7. Bits 0 and 1 never select analog. Writing 0 to a bit makes it a digital input.
- R3: No Port A bit ever drives its pin (`a_drive_en` is 0), whatever its latch holds.
- R4: With `ext_mem_mode` at 1, Port B drives push-pull from the address byte: `drv_hi_b` equals `addr_byte` and `drv_lo_b` equals its inverse.
- R5: While `ext_mem_mode` is 1, the Port B latch keeps its value unless software writes it. The address byte never lands in it.
- R6: With `ext_mem_mode` at 0, a Port B bit drives low exactly when its latch bit is 0, and it never drives high.
- R7: A Port C pin is driven low unless both its latch bit and its alternate output are 1. `drv_hi_c` is always 0.
- R8: The read select (0 = A, 1 = B, 2 = C, 3 = none, which reads zero) chooses the port. `rd_latch` returns its latch. `rd_pin` returns its pin level two clock edges after the pin changes. Port A bits in analog mode read 0 on the pin path. `rd_data` is `rd_latch` when `rd_rmw` is 1 and `rd_pin` otherwise.
- R9: `alt_in_c` equals the Port C pin level two clock edges earlier.
- R10: A write with port select 3 changes no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 2 | Port to write (0 A, 1 B, 2 C, 3 none) |
| wr_data | input | 8 | Latch write data |
| rd_sel | input | 2 | Port to read (same encoding as wr_sel) |
| rd_rmw | input | 1 | 1 selects the latch path onto rd_data |
| ext_mem_mode | input | 1 | Port B address override enable |
| addr_byte | input | 8 | Address byte for Port B |
| alt_out_c | input | 8 | Peripheral outputs for Port C |
| pin_a | input | 8 | Port A pin levels |
| pin_b | input | 8 | Port B pin levels |
| pin_c | input | 8 | Port C pin levels |
| a_drive_en | output | 8 | Port A drive enables (never set) |
| ana_sel_a | output | 8 | Port A analog select per bit |
| drv_lo_b | output | 8 | Port B drive-low enables |
| drv_hi_b | output | 8 | Port B drive-high enables |
| drv_lo_c | output | 8 | Port C drive-low enables |
| drv_hi_c | output | 8 | Port C drive-high enables |
| alt_in_c | output | 8 | Synchronized Port C levels for peripherals |
| rd_latch | output | 8 | Latch contents of the selected port |
| rd_pin | output | 8 | Synchronized pin level of the selected port |
| rd_data | output | 8 | Combined read data |

## Verification
The bench builds the block with its defaults: 8-bit ports, analog select from bit 2 upward and two synchronizer stages. At that width every one of the 256 latch values can be written to each port. Port A's analog mapping and Port B's drive in both modes are checked over the full value range. Port C's gating is checked for every latch value against four alternate-output patterns. With only two synchronizer stages, the read latency is checked edge by edge for every port.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    typedef enum logic [1:0] {
        PAD_INPUT_ONLY = 2'd0,
        PAD_ADDR_OVR   = 2'd1,
        PAD_ALT_GATED  = 2'd2
    } pad_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter pad_kind_e KIND  = PAD_ALT_GATED
) (
    input  logic [WIDTH-1:0] lat,
    input  logic             ovr_en,
    input  logic [WIDTH-1:0] ovr_val,
    input  logic [WIDTH-1:0] alt_val,
    output logic [WIDTH-1:0] drv_lo,
    output logic [WIDTH-1:0] drv_hi
);
    generate
        if (KIND == PAD_INPUT_ONLY) begin : g_in
            logic unused_in;
            assign unused_in = ^{lat, ovr_en, ovr_val, alt_val};
            assign drv_lo = '0;
            assign drv_hi = '0;
        end else if (KIND == PAD_ADDR_OVR) begin : g_ovr
            logic unused_ovr;
            assign unused_ovr = ^alt_val;
            assign drv_lo = ovr_en ? ~ovr_val : ~lat;
            assign drv_hi = ovr_en ?  ovr_val : '0;
        end else begin : g_alt
            logic unused_alt;
            assign unused_alt = ^{ovr_en, ovr_val};
            assign drv_lo = ~(lat & alt_val);
            assign drv_hi = '0;
        end
    endgenerate
endmodule

// File: rtl/gpio_port_bits.sv
module gpio_port_bits
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ANA_LO      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    input  logic             rd_rmw,
    input  logic             ext_mem_mode,
    input  logic [WIDTH-1:0] addr_byte,
    input  logic [WIDTH-1:0] alt_out_c,
    input  logic [WIDTH-1:0] pin_a,
    input  logic [WIDTH-1:0] pin_b,
    input  logic [WIDTH-1:0] pin_c,
    output logic [WIDTH-1:0] a_drive_en,
    output logic [WIDTH-1:0] ana_sel_a,
    output logic [WIDTH-1:0] drv_lo_b,
    output logic [WIDTH-1:0] drv_hi_b,
    output logic [WIDTH-1:0] drv_lo_c,
    output logic [WIDTH-1:0] drv_hi_c,
    output logic [WIDTH-1:0] alt_in_c,
    output logic [WIDTH-1:0] rd_latch,
    output logic [WIDTH-1:0] rd_pin,
    output logic [WIDTH-1:0] rd_data
);
    localparam int NPORT = 3;
    localparam int SW    = NPORT * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] lat_a;
        logic [WIDTH-1:0] lat_b;
        logic [WIDTH-1:0] lat_c;
    } latch_s;

    latch_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (port_sel_e'(wr_sel))
                SEL_A:    state_d.lat_a = wr_data;
                SEL_B:    state_d.lat_b = wr_data;
                SEL_C:    state_d.lat_c = wr_data;
                SEL_NONE: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '1;
        else        state_q <= state_d;
    end

    // pin synchronizers, all three ports in one bank
    logic [SW-1:0] sync_out;
    logic [WIDTH-1:0] sp_a, sp_b, sp_c;

    gpio_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din ({pin_c, pin_b, pin_a}),
        .dout (sync_out)
    );
    assign {sp_c, sp_b, sp_a} = sync_out;

    // analog select only on the upper bits of port A
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_ana
            if (i >= ANA_LO) begin : g_sel
                assign ana_sel_a[i] = state_q.lat_a[i];
            end else begin : g_dig
                assign ana_sel_a[i] = 1'b0;
            end
        end
    endgenerate

    logic [WIDTH-1:0] drv_hi_a, drv_lo_a;

    gpio_pad_ctl #(.WIDTH(WIDTH), .KIND(PAD_INPUT_ONLY)) i_pad_a (
        .lat (state_q.lat_a), .ovr_en (1'b0), .ovr_val ('0), .alt_val ('0),
        .drv_lo (drv_lo_a), .drv_hi (drv_hi_a)
    );
    gpio_pad_ctl #(.WIDTH(WIDTH), .KIND(PAD_ADDR_OVR)) i_pad_b (
        .lat (state_q.lat_b), .ovr_en (ext_mem_mode), .ovr_val (addr_byte),
        .alt_val ('0), .drv_lo (drv_lo_b), .drv_hi (drv_hi_b)
    );
    gpio_pad_ctl #(.WIDTH(WIDTH), .KIND(PAD_ALT_GATED)) i_pad_c (
        .lat (state_q.lat_c), .ovr_en (1'b0), .ovr_val ('0),
        .alt_val (alt_out_c), .drv_lo (drv_lo_c), .drv_hi (drv_hi_c)
    );

    assign a_drive_en = drv_lo_a | drv_hi_a;
    assign alt_in_c   = sp_c;

    always_comb begin
        unique case (port_sel_e'(rd_sel))
            SEL_A: begin
                rd_latch = state_q.lat_a;
                rd_pin   = sp_a & ~ana_sel_a;
            end
            SEL_B: begin
                rd_latch = state_q.lat_b;
                rd_pin   = sp_b;
            end
            SEL_C: begin
                rd_latch = state_q.lat_c;
                rd_pin   = sp_c;
            end
            SEL_NONE: begin
                rd_latch = '0;
                rd_pin   = '0;
            end
        endcase
        rd_data = rd_rmw ? rd_latch : rd_pin;
    end
endmodule

// File: rtl/gpio_port_bits_chk.sv
module gpio_port_bits_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             ext_mem_mode,
    input logic [WIDTH-1:0] addr_byte,
    input logic [WIDTH-1:0] alt_out_c,
    input logic [WIDTH-1:0] pin_c,
    input logic [WIDTH-1:0] lat_b,
    input logic [WIDTH-1:0] lat_c,
    input logic [WIDTH-1:0] drv_lo_b,
    input logic [WIDTH-1:0] drv_hi_b,
    input logic [WIDTH-1:0] drv_lo_c,
    input logic [WIDTH-1:0] alt_in_c
);
    logic [1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    p_addr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mem_mode |-> (drv_hi_b == addr_byte) && (drv_lo_b == ~addr_byte));

    p_latch_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mem_mode && !(wr_en && wr_sel == 2'd1)) |=> $stable(lat_b));

    p_gpio_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mem_mode |-> (drv_lo_b == ~lat_b) && (drv_hi_b == '0));

    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_lo_b & drv_hi_b) == '0);

    p_alt_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~lat_c | ~alt_out_c) & ~drv_lo_c) == '0);

    p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> alt_in_c == $past(pin_c, 2));
endmodule

bind gpio_port_bits gpio_port_bits_chk #(.WIDTH(WIDTH)) i_chk (
    .clk (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wr_sel (wr_sel),
    .ext_mem_mode (ext_mem_mode),
    .addr_byte (addr_byte),
    .alt_out_c (alt_out_c),
    .pin_c (pin_c),
    .lat_b (state_q.lat_b),
    .lat_c (state_q.lat_c),
    .drv_lo_b (drv_lo_b),
    .drv_hi_b (drv_hi_b),
    .drv_lo_c (drv_lo_c),
    .alt_in_c (alt_in_c)
);

// File: tb/test_gpio_port_bits.sv
module test_gpio_port_bits;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_sel = 2'd0;
    logic       rd_rmw = 1'b0;
    logic       ext_mem_mode = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic [7:0] alt_out_c = 8'hff;
    logic [7:0] pin_a = 8'h00, pin_b = 8'h00, pin_c = 8'h00;
    logic [7:0] a_drive_en, ana_sel_a, drv_lo_b, drv_hi_b, drv_lo_c, drv_hi_c;
    logic [7:0] alt_in_c, rd_latch, rd_pin, rd_data;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    gpio_port_bits i_gpio_port_bits (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_data (wr_data), .rd_sel (rd_sel), .rd_rmw (rd_rmw),
        .ext_mem_mode (ext_mem_mode), .addr_byte (addr_byte),
        .alt_out_c (alt_out_c), .pin_a (pin_a), .pin_b (pin_b), .pin_c (pin_c),
        .a_drive_en (a_drive_en), .ana_sel_a (ana_sel_a),
        .drv_lo_b (drv_lo_b), .drv_hi_b (drv_hi_b),
        .drv_lo_c (drv_lo_c), .drv_hi_c (drv_hi_c), .alt_in_c (alt_in_c),
        .rd_latch (rd_latch), .rd_pin (rd_pin), .rd_data (rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic write_port(input logic [1:0] sel, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        tick();
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic read_latch(input logic [1:0] sel, input logic [7:0] exp, input string req);
        rd_sel = sel; rd_rmw = 1'b1;
        #1;
        chk(req, rd_latch, exp);
        chk(req, rd_data, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        read_latch(2'd0, 8'hff, "R1 latch A");
        read_latch(2'd1, 8'hff, "R1 latch B");
        read_latch(2'd2, 8'hff, "R1 latch C");
        chk("R1 analog select", ana_sel_a, 8'hfc);
        chk("R1 B drive low", drv_lo_b, 8'h00);
        chk("R1 C drive low", drv_lo_c, 8'h00);

        // R2, R3: every port A value
        for (int v = 0; v < 256; v++) begin
            write_port(2'd0, 8'(v));
            chk("R2 analog map", ana_sel_a, 8'(v) & 8'hfc);
            chk("R3 no drive", a_drive_en, 8'h00);
            read_latch(2'd0, 8'(v), "R2 latch A");
        end

        // R4, R5, R6: every port B value in both modes
        for (int v = 0; v < 256; v++) begin
            write_port(2'd1, 8'(v));
            chk("R6 drive low", drv_lo_b, ~8'(v));
            chk("R6 drive high", drv_hi_b, 8'h00);
            @(negedge clk);
            ext_mem_mode = 1'b1; addr_byte = 8'(v) ^ 8'h5a;
            #1;
            chk("R4 addr high", drv_hi_b, 8'(v) ^ 8'h5a);
            chk("R4 addr low", drv_lo_b, ~(8'(v) ^ 8'h5a));
            tick(); tick();
            read_latch(2'd1, 8'(v), "R5 latch kept");
            @(negedge clk);
            ext_mem_mode = 1'b0;
            #1;
            chk("R6 back to latch", drv_lo_b, ~8'(v));
        end

        // R7: every port C value against four alternate patterns
        for (int v = 0; v < 256; v++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] alt;
                alt = (p == 0) ? 8'h00 : (p == 1) ? 8'hff : (p == 2) ? 8'ha5 : 8'h3c;
                alt_out_c = alt;
                write_port(2'd2, 8'(v));
                chk("R7 gated low", drv_lo_c, ~(8'(v) & alt));
                chk("R7 no high", drv_hi_c, 8'h00);
            end
        end

        // R8, R9: read paths and synchronizer lag; A latch 0f keeps bits 2,3 analog
        write_port(2'd0, 8'h0f);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] oldv, newv;
            oldv = 8'(k * 37);
            newv = 8'(k * 37 + 91);
            @(negedge clk);
            pin_a = oldv; pin_b = oldv ^ 8'hff; pin_c = oldv;
            tick(); tick(); tick();
            @(negedge clk);
            pin_a = newv; pin_b = newv ^ 8'hff; pin_c = newv;
            rd_sel = 2'(k % 3); rd_rmw = 1'b0;
            tick();
            chk("R9 one edge", alt_in_c, oldv);
            chk("R8 one edge", rd_pin,
                (k % 3 == 0) ? (oldv & 8'hf3) : (k % 3 == 1) ? (oldv ^ 8'hff) : oldv);
            tick();
            chk("R9 two edges", alt_in_c, newv);
            chk("R8 two edges", rd_pin,
                (k % 3 == 0) ? (newv & 8'hf3) : (k % 3 == 1) ? (newv ^ 8'hff) : newv);
            chk("R8 plain read", rd_data, rd_pin);
        end
        rd_sel = 2'd3; rd_rmw = 1'b1;
        #1;
        chk("R8 none latch", rd_latch, 8'h00);
        chk("R8 none pin", rd_pin, 8'h00);

        // R10: write to select 3 is ignored
        write_port(2'd1, 8'h96);
        write_port(2'd2, 8'h69);
        write_port(2'd3, 8'h00);
        read_latch(2'd0, 8'h0f, "R10 A unchanged");
        read_latch(2'd1, 8'h96, "R10 B unchanged");
        read_latch(2'd2, 8'h69, "R10 C unchanged");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule